// File: doc/BRIEF.md
# Audio link input frame generator

This block is the codec-side serializer of an AC-link style serial audio interface. On every frame it builds one 256-bit input frame: a 16-bit tag slot followed by twelve 20-bit data slots. It then shifts that frame out on a single data line, most significant bit first, one bit per bit clock. The tag announces whether the codec is ready and which data slots carry valid content. Each data slot is zero-filled when its flag is clear, and it also keeps fixed reserved bit ranges at zero.

The parallel inputs are a codec-ready flag, a status register echo (a 7-bit index and 16-bit data sharing one valid strobe), and a left/right pair of record samples sharing another valid strobe. A rising edge on the frame sync input starts a frame. On the bit-clock edge that sees the rise, every parallel input is captured into the shift register as a fully assembled frame. Nothing that changes on the inputs after that edge reaches the frame being sent.

Control is a two-state machine. In IDLE the line is held low. The transition IDLE→SHIFT ("start") fires on a sync rise. In SHIFT the transition "advance" steps the bit counter. At the last bit, "reload" (SHIFT→SHIFT) fires if a new sync rise coincides with the end of the frame; otherwise "finish" (SHIFT→IDLE) fires.

Top module: `aclink_in_framer`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `sdata` is 0.
- R2: The first clock edge at which `frame_sync` is high after having been low starts a frame when the block is idle; frame bit 255 appears on `sdata` right after that edge, and frame bit 255−k appears after the k-th following edge.
- R3: A frame lasts exactly 256 bit clocks. A sync rise seen on the edge that ends bit 0 starts the next frame with no gap; otherwise the block returns to idle.
- R4: Frame bit 255 (tag bit 15) equals codec-ready; when it is 0 every other bit of the frame is 0.
- R5: Tag bits 14 and 13 (frame bits 254, 253) are both ready AND status-valid; tag bits 12 and 11 (frame bits 252, 251) are both ready AND record-valid; tag bits 10..0 are 0.
- R6: Slot 1 (frame bits 239..220) carries the status index in its bits 18..12 (frame bits 238..232); slot bit 19 and bits 11..0 are 0.
- R7: Slot 2 (frame bits 219..200) carries the status data in its bits 19..4 (frame bits 219..204); its bits 3..0 are 0.
- R8: Slot 3 (frame bits 199..180) carries the left sample and slot 4 (frame bits 179..160) the right sample, each in slot bits 19..4, with slot bits 3..0 zero.
- R9: A data slot whose tag flag is 0 is sent as all zeros, whatever its parallel input holds.
- R10: Slots 5 through 12 (frame bits 159..0) are always 0.
- R11: Input changes after the frame-start edge do not affect the frame being sent.
- R12: A sync rise while a frame is in progress, other than on its final edge, is ignored: the frame continues unchanged and no new frame follows it.
- R13: Holding `frame_sync` high does not start a further frame; only a low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame sync; a rise starts a frame |
| codec_ready | input | 1 | Codec ready flag placed in tag bit 15 |
| stat_valid | input | 1 | Status echo (slots 1 and 2) is valid |
| stat_index | input | 7 | Echoed register index |
| stat_data | input | 16 | Echoed register data |
| rec_valid | input | 1 | Record samples (slots 3 and 4) are valid |
| rec_left | input | 16 | Left record sample |
| rec_right | input | 16 | Right record sample |
| sdata | output | 1 | Serial frame output, MSB first |

## Verification
Two of the block's functions can land on the same edge: the end of one frame (the "finish" transition) and the start of the next (a sync rise). The bench provokes this by raising sync on the very cycle the last bit is sampled. It judges both frames bit for bit against separately computed images, and it requires the second frame to begin with no idle bit. A similar overlap is provoked by pulsing sync in the middle of a frame and by changing every input right after capture; the frame must come out unchanged and the line must fall idle afterwards.

// File: rtl/aclink_in_pkg.sv
`timescale 1ns/1ps
package aclink_in_pkg;
    localparam int TAG_W     = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 12;
    localparam int FRAME_W   = TAG_W + SLOT_W * NUM_SLOTS;
    localparam int CNT_W     = $clog2(FRAME_W);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } fr_state_e;
endpackage

// File: rtl/aclink_slot_pack.sv
`timescale 1ns/1ps
module aclink_slot_pack
    import aclink_in_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int REG_W = 16,
    parameter int PCM_W = 16
) (
    input  logic               codec_ready,
    input  logic               stat_valid,
    input  logic [IDX_W-1:0]   stat_index,
    input  logic [REG_W-1:0]   stat_data,
    input  logic               rec_valid,
    input  logic [PCM_W-1:0]   rec_left,
    input  logic [PCM_W-1:0]   rec_right,
    output logic [FRAME_W-1:0] frame
);
    // index sits just below the top slot bit; data fields are left-aligned
    localparam int IDX_LSB = SLOT_W - 1 - IDX_W;
    localparam int REG_LSB = SLOT_W - REG_W;
    localparam int PCM_LSB = SLOT_W - PCM_W;
    localparam int TAG_PAD = TAG_W - 1 - NUM_SLOTS;

    logic [NUM_SLOTS:1]  slot_ok;
    logic [SLOT_W-1:0]   slot_raw [1:NUM_SLOTS];
    logic [TAG_W-1:0]    tag;

    always_comb begin
        slot_ok    = '0;
        slot_ok[1] = codec_ready & stat_valid;
        slot_ok[2] = codec_ready & stat_valid;
        slot_ok[3] = codec_ready & rec_valid;
        slot_ok[4] = codec_ready & rec_valid;
    end

    always_comb begin
        for (int s = 1; s <= NUM_SLOTS; s++) begin
            slot_raw[s] = '0;
        end
        slot_raw[1] = SLOT_W'(stat_index) << IDX_LSB;
        slot_raw[2] = SLOT_W'(stat_data)  << REG_LSB;
        slot_raw[3] = SLOT_W'(rec_left)   << PCM_LSB;
        slot_raw[4] = SLOT_W'(rec_right)  << PCM_LSB;
    end

    assign tag[TAG_W-1] = codec_ready;

    generate
        for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
            assign tag[TAG_W-1-s] = slot_ok[s];
            assign frame[FRAME_W-TAG_W-SLOT_W*(s-1)-1 -: SLOT_W] =
                slot_ok[s] ? slot_raw[s] : '0;
        end
        if (TAG_PAD > 0) begin : g_tag_pad
            assign tag[TAG_PAD-1:0] = '0;
        end
    endgenerate

    assign frame[FRAME_W-1 -: TAG_W] = tag;
endmodule

// File: rtl/aclink_frame_shifter.sv
`timescale 1ns/1ps
module aclink_frame_shifter
    import aclink_in_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               sdata
);
    logic [FRAME_W-1:0] sreg;

    // the shift register doubles as the frame holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= frame_in;
        end else if (shift) begin
            sreg <= {sreg[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdata = sreg[FRAME_W-1];
endmodule

// File: rtl/aclink_frame_ctrl.sv
`timescale 1ns/1ps
module aclink_frame_ctrl
    import aclink_in_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    output logic             load,
    output logic             shift,
    output fr_state_e        state,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             sync_q
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    fr_state_e        state_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             sync_rise;
    logic             at_last;

    assign sync_rise = frame_sync & ~sync_q;
    assign at_last   = (bit_cnt == LAST_BIT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sync_q  <= 1'b0;
        end else begin
            state   <= state_nx;
            bit_cnt <= cnt_nx;
            sync_q  <= frame_sync;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = bit_cnt;
        unique case (state)
            ST_IDLE: begin
                if (sync_rise) begin
                    state_nx = ST_SHIFT;    // start
                    cnt_nx   = '0;
                end
            end
            ST_SHIFT: begin
                if (at_last) begin
                    cnt_nx   = '0;
                    state_nx = sync_rise ? ST_SHIFT : ST_IDLE;  // reload / finish
                end else begin
                    cnt_nx   = bit_cnt + CNT_W'(1);              // advance
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        unique case (state)
            ST_IDLE:  load = sync_rise;
            ST_SHIFT: begin
                if (at_last && sync_rise) begin
                    load = 1'b1;
                end else begin
                    shift = 1'b1;   // last shift empties the register
                end
            end
        endcase
    end
endmodule

// File: rtl/aclink_in_framer.sv
`timescale 1ns/1ps
module aclink_in_framer
    import aclink_in_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int REG_W = 16,
    parameter int PCM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             codec_ready,
    input  logic             stat_valid,
    input  logic [IDX_W-1:0] stat_index,
    input  logic [REG_W-1:0] stat_data,
    input  logic             rec_valid,
    input  logic [PCM_W-1:0] rec_left,
    input  logic [PCM_W-1:0] rec_right,
    output logic             sdata
);
    logic [FRAME_W-1:0] frame;
    logic               load;
    logic               shift;
    fr_state_e          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic               sync_q;

    aclink_slot_pack #(
        .IDX_W (IDX_W),
        .REG_W (REG_W),
        .PCM_W (PCM_W)
    ) pack_i (
        .codec_ready (codec_ready),
        .stat_valid  (stat_valid),
        .stat_index  (stat_index),
        .stat_data   (stat_data),
        .rec_valid   (rec_valid),
        .rec_left    (rec_left),
        .rec_right   (rec_right),
        .frame       (frame)
    );

    aclink_frame_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .load       (load),
        .shift      (shift),
        .state      (state),
        .bit_cnt    (bit_cnt),
        .sync_q     (sync_q)
    );

    aclink_frame_shifter shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .frame_in (frame),
        .sdata    (sdata)
    );
endmodule

// File: rtl/aclink_in_framer_chk.sv
`timescale 1ns/1ps
module aclink_in_framer_chk
    import aclink_in_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frame_sync,
    input logic             sync_q,
    input fr_state_e        state,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             sdata
);
    localparam logic [CNT_W-1:0] C_LAST    = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] C_TPAD_LO = CNT_W'(NUM_SLOTS - 7);
    localparam logic [CNT_W-1:0] C_TPAD_HI = CNT_W'(TAG_W - 1);
    localparam logic [CNT_W-1:0] C_S1_TOP  = CNT_W'(TAG_W);
    localparam logic [CNT_W-1:0] C_S1_PLO  = CNT_W'(TAG_W + 8);
    localparam logic [CNT_W-1:0] C_S1_PHI  = CNT_W'(TAG_W + SLOT_W - 1);
    localparam logic [CNT_W-1:0] C_S3_PLO  = CNT_W'(TAG_W + 3*SLOT_W - 4);
    localparam logic [CNT_W-1:0] C_S3_PHI  = CNT_W'(TAG_W + 3*SLOT_W - 1);
    localparam logic [CNT_W-1:0] C_S4_PLO  = CNT_W'(TAG_W + 4*SLOT_W - 4);
    localparam logic [CNT_W-1:0] C_RESV    = CNT_W'(TAG_W + 4*SLOT_W);

    logic rise_seen;
    logic nr_frame;

    assign rise_seen = frame_sync & ~sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nr_frame <= 1'b0;
        end else if (state == ST_SHIFT && bit_cnt == '0) begin
            nr_frame <= ~sdata;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sdata);

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rise_seen) |=> (state == ST_SHIFT && bit_cnt == '0));

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && bit_cnt != C_LAST) |=>
        (state == ST_SHIFT && bit_cnt == $past(bit_cnt) + CNT_W'(1)));

    a_r3_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && bit_cnt == C_LAST && !rise_seen) |=> (state == ST_IDLE));

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && bit_cnt == C_LAST && rise_seen) |=>
        (state == ST_SHIFT && bit_cnt == '0));

    a_r13_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_sync && sync_q) |=> (state == ST_IDLE));

    a_r4_notready_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && bit_cnt != '0 && nr_frame) |-> !sdata);

    a_r5_tag_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && bit_cnt >= C_TPAD_LO && bit_cnt <= C_TPAD_HI) |-> !sdata);

    a_r6_slot1_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && (bit_cnt == C_S1_TOP ||
         (bit_cnt >= C_S1_PLO && bit_cnt <= C_S1_PHI))) |-> !sdata);

    a_r8_pcm_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && ((bit_cnt >= C_S3_PLO && bit_cnt <= C_S3_PHI) ||
         (bit_cnt >= C_S4_PLO && bit_cnt < C_RESV))) |-> !sdata);

    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && bit_cnt >= C_RESV) |-> !sdata);
endmodule

bind aclink_in_framer aclink_in_framer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .sync_q     (sync_q),
    .state      (state),
    .bit_cnt    (bit_cnt),
    .sdata      (sdata)
);

// File: tb/aclink_in_framer_tb.sv
`timescale 1ns/1ps
module aclink_in_framer_tb_top;
    typedef struct packed {
        logic        rdy;
        logic        sv;
        logic [6:0]  idx;
        logic [15:0] sd;
        logic        rv;
        logic [15:0] l;
        logic [15:0] r;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic        stat_valid = 1'b0;
    logic [6:0]  stat_index = '0;
    logic [15:0] stat_data = '0;
    logic        rec_valid = 1'b0;
    logic [15:0] rec_left = '0;
    logic [15:0] rec_right = '0;
    logic        sdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    aclink_in_framer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .codec_ready (codec_ready),
        .stat_valid  (stat_valid),
        .stat_index  (stat_index),
        .stat_data   (stat_data),
        .rec_valid   (rec_valid),
        .rec_left    (rec_left),
        .rec_right   (rec_right),
        .sdata       (sdata)
    );

    function automatic logic [255:0] exp_frame(stim_t s);
        logic [255:0] f;
        logic a;
        logic b;
        f = '0;
        a = s.rdy & s.sv;
        b = s.rdy & s.rv;
        f[255] = s.rdy;
        f[254] = a;
        f[253] = a;
        f[252] = b;
        f[251] = b;
        if (a) begin
            f[238:232] = s.idx;
            f[219:204] = s.sd;
        end
        if (b) begin
            f[199:184] = s.l;
            f[179:164] = s.r;
        end
        return f;
    endfunction

    function automatic string field_req(int pos);
        if (pos == 255) return "R4";
        if (pos >= 240) return "R5";
        if (pos >= 220) return "R6";
        if (pos >= 200) return "R7";
        if (pos >= 160) return "R8";
        return "R10";
    endfunction

    function automatic stim_t rnd_stim();
        stim_t s;
        s.rdy = ($urandom % 4) != 0;
        s.sv  = $urandom % 2;
        s.idx = 7'($urandom);
        s.sd  = 16'($urandom);
        s.rv  = $urandom % 2;
        s.l   = 16'($urandom);
        s.r   = 16'($urandom);
        return s;
    endfunction

    task automatic apply(stim_t s);
        codec_ready = s.rdy;
        stat_valid  = s.sv;
        stat_index  = s.idx;
        stat_data   = s.sd;
        rec_valid   = s.rv;
        rec_left    = s.l;
        rec_right   = s.r;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic cmp_frame(logic [255:0] got, logic [255:0] exp, string tag);
        n_vec++;
        if (got !== exp) begin
            int first;
            first = -1;
            for (int i = 255; i >= 0; i--) begin
                if (first < 0 && got[i] !== exp[i]) first = i;
            end
            n_bad++;
            $display("FAIL %s (field %s, bit %0d) got %h exp %h",
                     tag, field_req(first), first, got, exp);
        end
    endtask

    // inputs and sync for this frame must already be applied at the current negedge
    task automatic frame_body(stim_t s, bit mutate, bit midsync, bit hold,
                              bit chain, stim_t nxt, string tag);
        logic [255:0] got;
        got = '0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            got[255-k] = sdata;
            if (k == 0 && !hold) frame_sync = 1'b0;
            if (mutate) apply(rnd_stim());
            if (midsync && k == 100) frame_sync = 1'b1;
            if (midsync && k == 101) frame_sync = 1'b0;
            if (k == 255 && chain) begin
                apply(nxt);
                frame_sync = 1'b1;
            end
        end
        cmp_frame(got, exp_frame(s), tag);
    endtask

    task automatic idle_check(int n, string tag);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen = seen | sdata;
        end
        n_vec++;
        if (seen !== 1'b0) begin
            n_bad++;
            $display("FAIL %s idle line got %b exp 0", tag, seen);
        end
    endtask

    task automatic run(stim_t s, bit mutate, bit midsync, bit hold, string tag);
        @(negedge clk);
        apply(s);
        frame_sync = 1'b1;
        frame_body(s, mutate, midsync, hold, 1'b0, s, tag);
        if (hold) begin
            idle_check(20, {tag, " R13 held sync"});
            frame_sync = 1'b0;
        end else if (midsync) begin
            idle_check(300, {tag, " R12 no extra frame"});
        end else begin
            idle_check(3, {tag, " R1 after frame"});
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        stim_t a;
        stim_t b;
        void'($urandom(32'h1A2B3C4D));

        repeat (3) @(negedge clk);
        n_vec++;
        if (sdata !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset got %b exp 0", sdata);
        end
        rst_n = 1'b1;
        idle_check(5, "R1 after reset");

        a = '{rdy:1, sv:1, idx:7'h55, sd:16'hA5C3, rv:1, l:16'h8001, r:16'h7FFE};
        run(a, 0, 0, 0, "R2 R6 R7 R8 full frame");

        a = '{rdy:0, sv:1, idx:7'h7F, sd:16'hFFFF, rv:1, l:16'hFFFF, r:16'hFFFF};
        run(a, 0, 0, 0, "R4 not ready");

        a = '{rdy:1, sv:0, idx:7'h7F, sd:16'hFFFF, rv:1, l:16'h1234, r:16'hFEDC};
        run(a, 0, 0, 0, "R9 status invalid");

        a = '{rdy:1, sv:1, idx:7'h01, sd:16'h8000, rv:0, l:16'hFFFF, r:16'hFFFF};
        run(a, 0, 0, 0, "R9 record invalid");

        a = '{rdy:1, sv:0, idx:7'h7F, sd:16'hFFFF, rv:0, l:16'hFFFF, r:16'hFFFF};
        run(a, 0, 0, 0, "R5 tag only");

        a = '{rdy:1, sv:1, idx:7'h7F, sd:16'hFFFF, rv:1, l:16'hFFFF, r:16'hFFFF};
        run(a, 0, 0, 0, "R10 all ones");

        a = '{rdy:1, sv:1, idx:7'h2A, sd:16'h0F0F, rv:1, l:16'hC0DE, r:16'h0B0E};
        run(a, 1, 0, 0, "R11 inputs change mid-frame");

        a = '{rdy:1, sv:1, idx:7'h13, sd:16'h3C3C, rv:1, l:16'h0001, r:16'h8000};
        run(a, 0, 1, 0, "R12 sync pulse mid-frame");

        a = '{rdy:1, sv:0, idx:7'h00, sd:16'h0000, rv:1, l:16'h5A5A, r:16'hA5A5};
        run(a, 0, 0, 1, "R13 sync held high");

        a = '{rdy:1, sv:1, idx:7'h40, sd:16'h1111, rv:0, l:16'h0000, r:16'h0000};
        b = '{rdy:1, sv:0, idx:7'h3F, sd:16'hEEEE, rv:1, l:16'h2222, r:16'hDDDD};
        @(negedge clk);
        apply(a);
        frame_sync = 1'b1;
        frame_body(a, 0, 0, 0, 1, b, "R3 back-to-back first");
        frame_body(b, 0, 0, 0, 0, b, "R3 back-to-back second");
        idle_check(3, "R3 R1 after chain");

        for (int i = 0; i < 40; i++) begin
            a = rnd_stim();
            run(a, ($urandom % 3) == 0, ($urandom % 5) == 0, 1'b0, "R2 random frame");
        end

        summary();
    end
endmodule